// File: doc/BRIEF.md
# Six-Pin Port Bank Controller with Safe-State Override

This block controls a bank of six general-purpose pads from a small APB-style register bus. For every pin it holds an output latch, a digital-mode bit, separate pull-down and pull-up driver enables and a function code. The function code picks what reaches the pad: the latch, a level-shift mapping signal, a PWM/capture output, a UART signal on the upper four pins, or a low-power timer toggle on the last pin. The pad value of each pin can be read back through a two-flop synchroniser. Pad electrical settings (strength, slew, current limits, bias) are kept as plain read/write bits.

On top of the function path sits a per-pin safe-state override. Each pin has its own safe code: float, force high, force low, or stay on the normal path. The override applies while a software enable bit is set, or while the kill input is recognised. The kill input is either filtered, so it must be high on two consecutive clocks, or applied on the first clock. A per-pin lock protects a pin's mode, function and safe-state fields from later writes. The output latch stays writable on a locked pin.

A write takes effect on the access-phase clock edge. The pads are registered and follow one clock later. Read data is captured on the setup-phase edge and held through the access phase. There are no wait states.

Top module: `pbank_ctrl`

## Requirements
- R1: After reset, `pad_oe` and `pad_out` are all zero, and every register except the pin-value word reads zero.
- R2: Registers decode only when `paddr[11:8]` and `paddr[3:0]` are zero, using word index `paddr[7:4]`. The words are: 0 latch, 1 pin value, 2 mode, 3 drivers (pull-down bits 5:0, pull-up bits 21:16), 4 pad settings, 5 current limit, 7 function, 8 safe state, 9 lock. A write to any other address, or to word 1, changes nothing, and a read of an unmapped address returns zero.
- R3: Word 1 returns `pad_in` as sampled through two flops, so it reflects the pad value from two clocks before the setup edge of the read.
- R4: With function code 0, the pad value is the pin's latch bit. Each pad updates one clock after the write edge.
- R5: Function code 1 selects `lvl_i[i]` and code 2 selects `pwm_i[i]`. Each pin's code is at bits [2i+1:2i] of word 7, except pin 5, whose code is at bits 12:10.
- R6: Code 3 selects `uart_i[i-2]` on pins 2 to 5 (TX, RX, RTS, CTS) and gives 0 on pins 0 and 1. Code 4 on pin 5 selects `tmr_i`. Codes 5 to 7 give 0.
- R7: In normal operation, `pad_oe[i]` = mode[i] & ((pull-down[i] & ~v) | (pull-up[i] & v)), where v is the selected value. `pad_out[i]` is v while `pad_oe[i]` is set, and 0 otherwise.
- R8: Safe state is active while bit 16 of word 8 is set or the kill input is recognised. A pin's 2-bit safe code (bits [2i+1:2i] of word 8) then gives: 0 float (oe 0, out 0), 1 drive high, 2 drive low.
- R9: With bit 17 of word 8 set, `kill_i` being high before a clock edge applies the safe state at that edge.
- R10: With bit 17 clear, `kill_i` is recognised only if it is high before two consecutive edges. A one-clock pulse has no effect on the pads.
- R11: A pin with safe code 3 keeps its normal output while safe state is active.
- R12: While a pin's bit in word 9 is set, writes leave that pin's mode bit, function code and safe code unchanged. Its latch bit, and the safe enable and kill-mode bits, still take writes.
- R13: Word 4 stores only bits 0x00EF003F and word 5 only bits 0x00FF003F. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| kill_i | input | 1 | Safe-state request, synchronous to clk |
| lvl_i | input | 6 | Level-shift mapping signals per pin |
| pwm_i | input | 6 | PWM/capture outputs per pin |
| uart_i | input | 4 | UART TX, RX, RTS, CTS for pins 2..5 |
| tmr_i | input | 1 | Low-power timer toggle for pin 5 |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Registered pad drive value |
| pad_oe | output | 6 | Registered pad output enable |

## Verification
The assertions assume that `kill_i` and the peripheral inputs are synchronous to `clk`. They also assume that reset is held from time zero, and that a write never targets the lock word and a locked field in the same access. The stimulus drives every input just after the falling edge. It sends only complete two-phase transfers, to mapped and unmapped word addresses. It changes the kill level at most once per clock, so the filter sees clean levels. The expected pads and read data come from a cycle model of the registers, synchroniser and kill filter kept in the bench.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
  localparam int NPIN_DEF = 6;
  localparam int AW_DEF   = 12;
  localparam int DW_DEF   = 32;

  // word index taken from paddr[7:4]
  localparam logic [3:0] W_LATCH = 4'h0;
  localparam logic [3:0] W_PINV  = 4'h1;
  localparam logic [3:0] W_MODE  = 4'h2;
  localparam logic [3:0] W_DRV   = 4'h3;
  localparam logic [3:0] W_PAD   = 4'h4;
  localparam logic [3:0] W_ILIM  = 4'h5;
  localparam logic [3:0] W_FSEL  = 4'h7;
  localparam logic [3:0] W_SAFE  = 4'h8;
  localparam logic [3:0] W_LOCK  = 4'h9;

  localparam int PEN_LSB    = 16;
  localparam int SS_EN_BIT  = 16;
  localparam int SS_IMM_BIT = 17;
  localparam int FS_W       = 3;
  localparam int FS_W_LO    = 2;
  localparam int SS_W       = 2;
  localparam int UART_FIRST = 2;
  localparam int NUART      = 4;

  localparam logic [31:0] PAD_MASK  = 32'h00EF_003F;
  localparam logic [31:0] ILIM_MASK = 32'h00FF_003F;

  typedef enum logic [1:0] {
    SS_HIZ  = 2'd0,
    SS_HIGH = 2'd1,
    SS_LOW  = 2'd2,
    SS_PASS = 2'd3
  } ss_code_e;

  localparam logic [2:0] FS_GPIO = 3'd0;
  localparam logic [2:0] FS_LVL  = 3'd1;
  localparam logic [2:0] FS_PWM  = 3'd2;
  localparam logic [2:0] FS_ALT  = 3'd3;
  localparam logic [2:0] FS_TMR  = 3'd4;
endpackage

// File: rtl/pbank_sync.sv
module pbank_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pbank_kill.sv
module pbank_kill (
  input  logic clk,
  input  logic rst,
  input  logic kill_i,
  input  logic imm,
  output logic kill_act
);
  logic kill_d1;

  always_ff @(posedge clk) begin
    if (rst) kill_d1 <= 1'b0;
    else     kill_d1 <= kill_i;
  end

  // filtered mode needs the level on two consecutive edges
  assign kill_act = imm ? kill_i : (kill_i & kill_d1);

  // R10
  deglitch_chk: assert property (@(posedge clk) disable iff (rst)
    (!imm && kill_act) |-> $past(kill_i));
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
  import pbank_pkg::*;
#(
  parameter int NPIN = NPIN_DEF,
  parameter int AW   = AW_DEF,
  parameter int DW   = DW_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [AW-1:0]              paddr,
  input  logic [DW-1:0]              pwdata,
  output logic [DW-1:0]              prdata,
  input  logic [NPIN-1:0]            pin_sync,
  output logic [NPIN-1:0]            latch_q,
  output logic [NPIN-1:0]            mode_q,
  output logic [NPIN-1:0]            nen_q,
  output logic [NPIN-1:0]            pen_q,
  output logic [NPIN-1:0][FS_W-1:0]  fsel_q,
  output logic [NPIN-1:0][SS_W-1:0]  ssel_q,
  output logic                       ss_en_q,
  output logic                       imm_q
);
  localparam int FS_LAST = FS_W_LO * (NPIN - 1);

  logic [NPIN-1:0] lock_q;
  logic [DW-1:0]   padctl_q;
  logic [DW-1:0]   ilim_q;
  logic            hit;
  logic [3:0]      word;
  logic            wr_fire;
  logic            rd_setup;
  logic [DW-1:0]   rd_v;
  logic [DW-1:0]   fs_pk;
  logic [DW-1:0]   ss_pk;

  assign word     = paddr[7:4];
  assign hit      = (paddr[AW-1:8] == '0) && (paddr[3:0] == 4'h0);
  assign wr_fire  = psel && penable && pwrite && hit;
  assign rd_setup = psel && !penable && !pwrite;

  // bank-wide fields, never locked
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '0;
      nen_q    <= '0;
      pen_q    <= '0;
      lock_q   <= '0;
      padctl_q <= '0;
      ilim_q   <= '0;
      ss_en_q  <= 1'b0;
      imm_q    <= 1'b0;
    end else if (wr_fire) begin
      case (word)
        W_LATCH: latch_q <= pwdata[NPIN-1:0];
        W_DRV: begin
          nen_q <= pwdata[NPIN-1:0];
          pen_q <= pwdata[PEN_LSB +: NPIN];
        end
        W_PAD:  padctl_q <= pwdata & DW'(PAD_MASK);
        W_ILIM: ilim_q   <= pwdata & DW'(ILIM_MASK);
        W_SAFE: begin
          ss_en_q <= pwdata[SS_EN_BIT];
          imm_q   <= pwdata[SS_IMM_BIT];
        end
        W_LOCK: lock_q <= pwdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  // per-pin fields guarded by the lock bit
  for (genvar i = 0; i < NPIN; i++) begin : g_pinreg
    localparam int FW = (i == NPIN - 1) ? FS_W : FS_W_LO;

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i] <= 1'b0;
        fsel_q[i] <= '0;
        ssel_q[i] <= '0;
      end else if (wr_fire && !lock_q[i]) begin
        if (word == W_MODE) mode_q[i] <= pwdata[i];
        if (word == W_FSEL) fsel_q[i] <= FS_W'(pwdata[FS_W_LO*i +: FW]);
        if (word == W_SAFE) ssel_q[i] <= pwdata[SS_W*i +: SS_W];
      end
    end

    // R12
    lock_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && word == W_MODE && lock_q[i]) |=> $stable(mode_q[i]));
    // R12
    lock_safe_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && word == W_SAFE && lock_q[i]) |=> $stable(ssel_q[i]));
    // R12
    lock_fsel_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && word == W_FSEL && lock_q[i]) |=> $stable(fsel_q[i]));
  end

  always_comb begin
    fs_pk = '0;
    ss_pk = '0;
    for (int i = 0; i < NPIN - 1; i++) begin
      fs_pk[FS_W_LO*i +: FS_W_LO] = fsel_q[i][FS_W_LO-1:0];
    end
    fs_pk[FS_LAST +: FS_W] = fsel_q[NPIN-1];
    for (int i = 0; i < NPIN; i++) begin
      ss_pk[SS_W*i +: SS_W] = ssel_q[i];
    end
    ss_pk[SS_EN_BIT]  = ss_en_q;
    ss_pk[SS_IMM_BIT] = imm_q;
  end

  always_comb begin
    rd_v = '0;
    if (hit) begin
      case (word)
        W_LATCH: rd_v[NPIN-1:0] = latch_q;
        W_PINV:  rd_v[NPIN-1:0] = pin_sync;
        W_MODE:  rd_v[NPIN-1:0] = mode_q;
        W_DRV: begin
          rd_v[NPIN-1:0]         = nen_q;
          rd_v[PEN_LSB +: NPIN]  = pen_q;
        end
        W_PAD:  rd_v = padctl_q;
        W_ILIM: rd_v = ilim_q;
        W_FSEL: rd_v = fs_pk;
        W_SAFE: rd_v = ss_pk;
        W_LOCK: rd_v[NPIN-1:0] = lock_q;
        default: rd_v = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_v;
  end

  // R13
  pad_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (padctl_q & ~DW'(PAD_MASK)) == '0);
endmodule

// File: rtl/pbank_pin.sv
module pbank_pin
  import pbank_pkg::*;
#(
  parameter bit HAS_ALT = 1'b0,
  parameter bit HAS_TMR = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            latch_b,
  input  logic            mode_b,
  input  logic            nen_b,
  input  logic            pen_b,
  input  logic [FS_W-1:0] fsel,
  input  logic [SS_W-1:0] ssel,
  input  logic            safe_act,
  input  logic            lvl_b,
  input  logic            pwm_b,
  input  logic            alt_b,
  input  logic            tmr_b,
  output logic            pad_out,
  output logic            pad_oe
);
  logic v;
  logic nrm_oe;
  logic nxt_out;
  logic nxt_oe;

  always_comb begin
    case (fsel)
      FS_GPIO: v = latch_b;
      FS_LVL:  v = lvl_b;
      FS_PWM:  v = pwm_b;
      FS_ALT:  v = HAS_ALT ? alt_b : 1'b0;
      FS_TMR:  v = HAS_TMR ? tmr_b : 1'b0;
      default: v = 1'b0;
    endcase
  end

  // pull-down leg drives a 0, pull-up leg drives a 1
  assign nrm_oe = mode_b & ((nen_b & ~v) | (pen_b & v));

  always_comb begin
    nxt_oe  = nrm_oe;
    nxt_out = nrm_oe & v;
    if (safe_act) begin
      case (ssel)
        SS_HIZ:  begin nxt_oe = 1'b0; nxt_out = 1'b0; end
        SS_HIGH: begin nxt_oe = 1'b1; nxt_out = 1'b1; end
        SS_LOW:  begin nxt_oe = 1'b1; nxt_out = 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  // R8
  safe_high_chk: assert property (@(posedge clk) disable iff (rst)
    (safe_act && ssel == SS_HIGH) |=> (pad_oe && pad_out));
  // R8
  safe_low_chk: assert property (@(posedge clk) disable iff (rst)
    (safe_act && ssel == SS_LOW) |=> (pad_oe && !pad_out));
  // R8
  safe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (safe_act && ssel == SS_HIZ) |=> (!pad_oe && !pad_out));
  // R7
  no_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_b && !(safe_act && ssel != SS_PASS)) |=> !pad_oe);
  // R7
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pad_oe |-> !pad_out);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pad_oe && !pad_out));
endmodule

// File: rtl/pbank_ctrl.sv
module pbank_ctrl
  import pbank_pkg::*;
#(
  parameter int NPIN = NPIN_DEF,
  parameter int AW   = AW_DEF,
  parameter int DW   = DW_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  input  logic             kill_i,
  input  logic [NPIN-1:0]  lvl_i,
  input  logic [NPIN-1:0]  pwm_i,
  input  logic [NUART-1:0] uart_i,
  input  logic             tmr_i,
  input  logic [NPIN-1:0]  pad_in,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe
);
  logic [NPIN-1:0]            pin_sync;
  logic [NPIN-1:0]            latch_q;
  logic [NPIN-1:0]            mode_q;
  logic [NPIN-1:0]            nen_q;
  logic [NPIN-1:0]            pen_q;
  logic [NPIN-1:0][FS_W-1:0]  fsel_q;
  logic [NPIN-1:0][SS_W-1:0]  ssel_q;
  logic                       ss_en_q;
  logic                       imm_q;
  logic                       kill_act;
  logic                       safe_act;

  pbank_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  pbank_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .pin_sync (pin_sync),
    .latch_q  (latch_q),
    .mode_q   (mode_q),
    .nen_q    (nen_q),
    .pen_q    (pen_q),
    .fsel_q   (fsel_q),
    .ssel_q   (ssel_q),
    .ss_en_q  (ss_en_q),
    .imm_q    (imm_q)
  );

  pbank_kill u_kill (
    .clk      (clk),
    .rst      (rst),
    .kill_i   (kill_i),
    .imm      (imm_q),
    .kill_act (kill_act)
  );

  assign safe_act = ss_en_q | kill_act;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam bit IS_ALT = (i >= UART_FIRST) && (i < UART_FIRST + NUART);
    localparam bit IS_TMR = (i == NPIN - 1);
    logic alt_s;

    if (IS_ALT) begin : g_alt
      assign alt_s = uart_i[i - UART_FIRST];
    end else begin : g_noalt
      assign alt_s = 1'b0;
    end

    pbank_pin #(.HAS_ALT(IS_ALT), .HAS_TMR(IS_TMR)) u_pin (
      .clk      (clk),
      .rst      (rst),
      .latch_b  (latch_q[i]),
      .mode_b   (mode_q[i]),
      .nen_b    (nen_q[i]),
      .pen_b    (pen_q[i]),
      .fsel     (fsel_q[i]),
      .ssel     (ssel_q[i]),
      .safe_act (safe_act),
      .lvl_b    (lvl_i[i]),
      .pwm_b    (pwm_i[i]),
      .alt_b    (alt_s),
      .tmr_b    (tmr_i),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i])
    );
  end

  // R9
  imm_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_q && kill_i && ssel_q[0] == SS_HIGH) |=> (pad_oe[0] && pad_out[0]));
endmodule

// File: tb/pbank_ctrl_tb.sv
module pbank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        kill_i = 1'b0;
  logic [5:0]  lvl_i = '0, pwm_i = '0, pad_in = '0;
  logic [3:0]  uart_i = '0;
  logic        tmr_i = 1'b0;
  logic [5:0]  pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic cur_kill = 1'b0;

  // bench model
  logic [5:0]  m_latch = '0, m_mode = '0, m_nen = '0, m_pen = '0, m_lock = '0;
  logic [2:0]  m_fsel [6];
  logic [1:0]  m_ssel [6];
  logic        m_en = 1'b0, m_imm = 1'b0;
  logic [31:0] m_pad = '0, m_ilim = '0;
  logic [5:0]  m_s1 = '0, m_s2 = '0;
  logic        m_kprev = 1'b0;
  logic [31:0] m_prd = '0;
  logic [5:0]  e_out, e_oe;

  pbank_ctrl u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .kill_i(kill_i),
    .lvl_i(lvl_i), .pwm_i(pwm_i), .uart_i(uart_i), .tmr_i(tmr_i),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic src_of(int i);
    logic r;
    case (m_fsel[i])
      3'd0: r = m_latch[i];
      3'd1: r = lvl_i[i];
      3'd2: r = pwm_i[i];
      3'd3: begin r = 1'b0; if (i >= 2) r = uart_i[i-2]; end
      3'd4: r = (i == 5) ? tmr_i : 1'b0;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  task automatic calc_pads(input logic kact);
    logic safe;
    safe = m_en | kact;
    for (int i = 0; i < 6; i++) begin
      logic v, oe;
      v  = src_of(i);
      oe = m_mode[i] & ((m_nen[i] & ~v) | (m_pen[i] & v));
      e_oe[i]  = oe;
      e_out[i] = oe & v;
      if (safe) begin
        case (m_ssel[i])
          2'd0: begin e_oe[i] = 1'b0; e_out[i] = 1'b0; end
          2'd1: begin e_oe[i] = 1'b1; e_out[i] = 1'b1; end
          2'd2: begin e_oe[i] = 1'b1; e_out[i] = 1'b0; end
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [31:0] rd_model(logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a[11:8] == 4'h0 && a[3:0] == 4'h0) begin
      case (a[7:4])
        4'h0: r[5:0] = m_latch;
        4'h1: r[5:0] = m_s2;
        4'h2: r[5:0] = m_mode;
        4'h3: begin r[5:0] = m_nen; r[21:16] = m_pen; end
        4'h4: r = m_pad;
        4'h5: r = m_ilim;
        4'h7: begin
          for (int i = 0; i < 5; i++) r[2*i +: 2] = m_fsel[i][1:0];
          r[12:10] = m_fsel[5];
        end
        4'h8: begin
          for (int i = 0; i < 6; i++) r[2*i +: 2] = m_ssel[i];
          r[16] = m_en; r[17] = m_imm;
        end
        4'h9: r[5:0] = m_lock;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    logic [5:0] lk;
    lk = m_lock;
    if (a[11:8] != 4'h0 || a[3:0] != 4'h0) return;
    case (a[7:4])
      4'h0: m_latch = d[5:0];
      4'h2: for (int i = 0; i < 6; i++) if (!lk[i]) m_mode[i] = d[i];
      4'h3: begin m_nen = d[5:0]; m_pen = d[21:16]; end
      4'h4: m_pad = d & 32'h00EF_003F;
      4'h5: m_ilim = d & 32'h00FF_003F;
      4'h7: begin
        for (int i = 0; i < 5; i++) if (!lk[i]) m_fsel[i] = {1'b0, d[2*i +: 2]};
        if (!lk[5]) m_fsel[5] = d[12:10];
      end
      4'h8: begin
        for (int i = 0; i < 6; i++) if (!lk[i]) m_ssel[i] = d[2*i +: 2];
        m_en = d[16]; m_imm = d[17];
      end
      4'h9: m_lock = d[5:0];
      default: ;
    endcase
  endtask

  // one clock: drive after negedge, check pads at the next negedge
  task automatic tick(input logic s, input logic en, input logic w,
                      input logic [11:0] a, input logic [31:0] d);
    logic kact, wf, rs;
    logic [31:0] prd_e;
    psel = s; penable = en; pwrite = w; paddr = a; pwdata = d;
    kill_i = cur_kill;
    lvl_i  = 6'($urandom); pwm_i = 6'($urandom);
    uart_i = 4'($urandom); tmr_i = 1'($urandom);
    pad_in = 6'($urandom);
    kact = m_imm ? cur_kill : (cur_kill & m_kprev);
    calc_pads(kact);
    wf = s & en & w;
    rs = s & ~en & ~w;
    prd_e = rd_model(a);
    @(posedge clk);
    if (wf) model_write(a, d);
    m_s2 = m_s1; m_s1 = pad_in;
    m_kprev = cur_kill;
    if (rs) m_prd = prd_e;
    @(negedge clk);
    n_chk++;
    if (pad_out !== e_out || pad_oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s pads: actual out=%b oe=%b expected out=%b oe=%b",
               cur_req, pad_out, pad_oe, e_out, e_oe);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    tick(1'b1, 1'b0, 1'b1, a, d);
    tick(1'b1, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(logic [11:0] a, string req);
    tick(1'b1, 1'b0, 1'b0, a, 32'h0);
    n_chk++;
    if (prdata !== m_prd) begin
      n_bad++;
      $display("FAIL %s read 0x%03h: actual 0x%08h expected 0x%08h",
               req, a, prdata, m_prd);
    end
    tick(1'b1, 1'b1, 1'b0, a, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h0BAD_5EED));
    for (int i = 0; i < 6; i++) begin m_fsel[i] = '0; m_ssel[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    n_chk++;
    if (pad_oe !== 6'h0 || pad_out !== 6'h0) begin
      n_bad++;
      $display("FAIL R1 reset pads: actual oe=%b out=%b expected 0", pad_oe, pad_out);
    end
    foreach (m_pad[k]) begin end
    rd(12'h000, "R1"); rd(12'h020, "R1"); rd(12'h030, "R1"); rd(12'h040, "R1");
    rd(12'h050, "R1"); rd(12'h070, "R1"); rd(12'h080, "R1"); rd(12'h090, "R1");

    // R13 / R2: masks, unmapped and read-only words
    cur_req = "R13";
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, "R13");
    wr(12'h050, 32'hFFFF_FFFF); rd(12'h050, "R13");
    cur_req = "R2";
    wr(12'h010, 32'h0000_003F); rd(12'h010, "R2");
    wr(12'h060, 32'hFFFF_FFFF); rd(12'h060, "R2");
    wr(12'h104, 32'h0000_003F); rd(12'h000, "R2");
    wr(12'h024, 32'h0000_003F); rd(12'h020, "R2");
    rd(12'h100, "R2");

    // R3: synchronised pin value
    cur_req = "R3";
    for (int k = 0; k < 4; k++) rd(12'h010, "R3");

    // R4: GPIO path
    cur_req = "R4";
    wr(12'h020, 32'h3F); wr(12'h030, 32'h003F_003F);
    wr(12'h000, 32'h2A); idle(1); wr(12'h000, 32'h15); wr(12'h000, 32'h3F);
    wr(12'h000, 32'h00); rd(12'h000, "R4");

    // R5: level-shift and PWM sources
    cur_req = "R5";
    wr(12'h070, 32'h0555); idle(4); rd(12'h070, "R5");
    wr(12'h070, 32'h0AAA); idle(4);

    // R6: UART, reserved, timer and unused codes
    cur_req = "R6";
    wr(12'h070, 32'h0FFF); idle(6); rd(12'h070, "R6");
    wr(12'h070, 32'h1000); idle(6);
    wr(12'h070, 32'h1C00); idle(3); rd(12'h070, "R6");

    // R7: single-leg drivers and mode gating
    cur_req = "R7";
    wr(12'h070, 32'h0555);
    wr(12'h030, 32'h0000_003F); idle(5);
    wr(12'h030, 32'h003F_0000); idle(5);
    wr(12'h030, 32'h003F_003F); wr(12'h020, 32'h00); idle(4);
    wr(12'h020, 32'h3F);

    // R8: forced safe codes via the enable bit
    cur_req = "R8";
    wr(12'h080, 32'h0001_0999); idle(3); rd(12'h080, "R8");
    wr(12'h080, 32'h0001_0000); idle(3);
    wr(12'h080, 32'h0000_0999); idle(2);

    // R9: immediate kill
    cur_req = "R9";
    wr(12'h080, 32'h0002_0999);
    cur_kill = 1'b1; idle(1); cur_kill = 1'b0; idle(2);
    cur_kill = 1'b1; idle(3); cur_kill = 1'b0; idle(2);

    // R10: filtered kill, one-clock pulse and held level
    cur_req = "R10";
    wr(12'h080, 32'h0000_0999);
    cur_kill = 1'b1; idle(1); cur_kill = 1'b0; idle(2);
    cur_kill = 1'b1; idle(2); cur_kill = 1'b0; idle(1);
    cur_kill = 1'b1; idle(4); cur_kill = 1'b0; idle(2);

    // R11: pass-through code while safe state is active
    cur_req = "R11";
    wr(12'h080, 32'h0001_0FFF); idle(4);
    wr(12'h080, 32'h0001_0F3C); idle(3);
    wr(12'h080, 32'h0000_0000);

    // R12: lock protects pin fields, latch and global bits stay writable
    cur_req = "R12";
    wr(12'h090, 32'h15); rd(12'h090, "R12");
    wr(12'h020, 32'h00); rd(12'h020, "R12");
    wr(12'h070, 32'h1FFF); rd(12'h070, "R12");
    wr(12'h080, 32'h0003_0AAA); rd(12'h080, "R12");
    wr(12'h000, 32'h2A); rd(12'h000, "R12"); idle(2);
    wr(12'h090, 32'h00);
    wr(12'h080, 32'h0000_0000);

    // mixed random traffic
    cur_req = "R2 R8 R10 R12";
    for (int k = 0; k < 500; k++) begin
      int sel;
      logic [11:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      a = {4'h0, 4'(sel), 4'h0};
      d = $urandom;
      if ($urandom_range(0, 3) == 0) cur_kill = ~cur_kill;
      case ($urandom_range(0, 3))
        0: rd(a, "R2");
        1: idle(1);
        default: wr(a, d);
      endcase
    end
    cur_kill = 1'b0; idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule